// File: doc/BRIEF.md
# Burst PN Spreader with Data Request

This block sequences the baseband side of a direct-sequence burst transmitter. It runs on the IF clock and moves forward one chip each time the chip strobe `chip_en_i` is high at a clock edge. A burst opens with a single preamble symbol spread by the preamble code. Data symbols follow, each spread by a separate data code. The two codes are up to 64 chips long, and each has its own length setting that holds the chip count minus one. Within every symbol the chips go out from code index N-1 down to index 0.

Input data is pulled rather than pushed. The block raises `req_o` for one chip, and the source must then present the bit on `data_i`. The bit is captured at the chip strobe that ends that chip and takes effect from the next symbol on. BPSK takes one bit per symbol and QPSK takes two.

A 16-bit burst length sets the number of data symbols minus one. A value of zero selects continuous transmission, which runs until `tx_en_i` drops. An invert control flips the encoded symbol bits before they are spread.

Top module: `pn_burst_spreader`

## Requirements
- R1: After reset `active_o`, `preamble_o`, `req_o`, `chip_i_o` and `chip_q_o` are all 0.
- R2: A burst starts at a clock edge where the block is idle and both `chip_en_i` and `tx_en_i` are high. It begins with exactly one preamble symbol of `pre_len_i`+1 chips taken from `pre_code_i`, and `preamble_o` and `active_o` are high during that symbol. While `tx_en_i` is low no burst starts.
- R3: Every symbol sends code bit N-1 first and code bit 0 last, one chip per strobe. Data symbols use `dat_code_i` with `dat_len_i`+1 chips.
- R4: Each output chip equals the symbol bit XOR the current code bit. The preamble symbol bit is 0. Both chip outputs are 0 while idle.
- R5: With `bpsk_i`=1, `req_o` is high during the last chip (index 0) of each symbol. The bit on `data_i` is captured at the strobe that ends that chip and drives both I and Q of the next symbol, so `chip_q_o` always equals `chip_i_o`.
- R6: With `bpsk_i`=0 (QPSK), `req_o` is high during the chip of index N-floor(N/2), where N is the symbol's chip count, and again during index 0. The first captured bit becomes I and the second becomes Q of the next symbol.
- R7: `req_o` is high only while `tx_en_i` is high. It is never raised during the final data symbol of a counted burst. It goes low after the strobe that captures the bit.
- R8: With `burst_len_i`=M, where M is not 0, exactly M+1 data symbols are sent. The block is idle right after the strobe that ends the last one.
- R9: With `burst_len_i`=0 data symbols repeat without limit. If `tx_en_i` is low at the end of a symbol, the block goes idle after that symbol completes.
- R10: `invert_i`=1 flips the I and Q symbol bits, including the preamble, before they are spread.
- R11: When `chip_en_i` is low, the chip position, the symbol bits and the request output stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | IF clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chip_en_i | input | 1 | Chip strobe, one chip per high cycle |
| tx_en_i | input | 1 | Transmit enable |
| bpsk_i | input | 1 | 1 selects BPSK, 0 selects QPSK |
| invert_i | input | 1 | Invert the encoded symbol bits |
| pre_code_i | input | 64 | Preamble code chips |
| pre_len_i | input | 6 | Preamble chip count minus one (1 to 63) |
| dat_code_i | input | 64 | Data code chips |
| dat_len_i | input | 6 | Data chip count minus one (1 to 63) |
| burst_len_i | input | 16 | Data symbols per burst minus one; 0 means continuous |
| data_i | input | 1 | Data bit, captured when `req_o` is high at a strobe |
| req_o | output | 1 | Data request |
| chip_i_o | output | 1 | I-channel chip |
| chip_q_o | output | 1 | Q-channel chip |
| active_o | output | 1 | A burst is in progress |
| preamble_o | output | 1 | The preamble symbol is in progress |

## Verification
A chip index that is off by one shows up at once as a wrong chip value. A wrong index also moves the request pulse: by one chip for the end request, or to the wrong chip for the QPSK middle request. Any of these is visible within the first symbol.

Mis-steering a captured bit has a delayed effect. If a bit lands in the wrong channel, or is taken at the wrong strobe, it corrupts every chip of the following symbol, which can be a full symbol later. An off-by-one in the symbol counter only appears at the end of a burst, as one symbol too many or too few. It is seen in the cycle where `active_o` should have fallen.

// File: rtl/pn_spread_pkg.sv
package pn_spread_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } tx_st_e;
endpackage

// File: rtl/pn_code_mux.sv
module pn_code_mux #(
  parameter int CODE_W = 64,
  parameter int LEN_W  = $clog2(CODE_W)
) (
  input  logic              sel_pre_i,
  input  logic [CODE_W-1:0] pre_code_i,
  input  logic [CODE_W-1:0] dat_code_i,
  input  logic [LEN_W-1:0]  pre_len_i,
  input  logic [LEN_W-1:0]  dat_len_i,
  input  logic [LEN_W-1:0]  idx_i,
  output logic              code_bit_o,
  output logic [LEN_W-1:0]  cur_len_o
);
  assign code_bit_o = sel_pre_i ? pre_code_i[idx_i] : dat_code_i[idx_i];
  assign cur_len_o  = sel_pre_i ? pre_len_i : dat_len_i;
endmodule

// File: rtl/pn_req_gen.sv
module pn_req_gen #(
  parameter int LEN_W = 6
) (
  input  logic [LEN_W-1:0] cur_len_i,
  input  logic [LEN_W-1:0] idx_i,
  output logic             at_mid_o,
  output logic             at_end_o
);
  logic [LEN_W:0] n_chips, mid_idx;

  // midpoint: the chip after which floor(N/2) chips have gone out
  assign n_chips  = {1'b0, cur_len_i} + 1'b1;
  assign mid_idx  = n_chips - (n_chips >> 1);
  assign at_mid_o = ({1'b0, idx_i} == mid_idx);
  assign at_end_o = (idx_i == '0);
endmodule

// File: rtl/pn_sym_ctr.sv
module pn_sym_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic             in_data_i,
  input  logic [CNT_W-1:0] burst_len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = in_data_i && (burst_len_i != '0) && (cnt_q == burst_len_i);
endmodule

// File: rtl/pn_burst_spreader.sv
module pn_burst_spreader
  import pn_spread_pkg::*;
#(
  parameter int CODE_W = 64,
  parameter int CNT_W  = 16,
  localparam int LEN_W = $clog2(CODE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              chip_en_i,
  input  logic              tx_en_i,
  input  logic              bpsk_i,
  input  logic              invert_i,
  input  logic [CODE_W-1:0] pre_code_i,
  input  logic [LEN_W-1:0]  pre_len_i,
  input  logic [CODE_W-1:0] dat_code_i,
  input  logic [LEN_W-1:0]  dat_len_i,
  input  logic [CNT_W-1:0]  burst_len_i,
  input  logic              data_i,
  output logic              req_o,
  output logic              chip_i_o,
  output logic              chip_q_o,
  output logic              active_o,
  output logic              preamble_o
);
  tx_st_e           st_q;
  logic [LEN_W-1:0] idx_q, cur_len;
  logic             sym_i_q, sym_q_q, nxt_i_q;
  logic             code_bit, at_mid, at_end, last_sym;
  logic             in_burst, in_pre, in_data, req, sym_end, start;
  logic [CNT_W-1:0] sym_cnt;

  assign in_burst = (st_q != ST_IDLE);
  assign in_pre   = (st_q == ST_PRE);
  assign in_data  = (st_q == ST_DATA);

  pn_code_mux #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_mux (
    .sel_pre_i (in_pre),
    .pre_code_i(pre_code_i),
    .dat_code_i(dat_code_i),
    .pre_len_i (pre_len_i),
    .dat_len_i (dat_len_i),
    .idx_i     (idx_q),
    .code_bit_o(code_bit),
    .cur_len_o (cur_len)
  );

  pn_req_gen #(.LEN_W(LEN_W)) u_req (
    .cur_len_i(cur_len),
    .idx_i    (idx_q),
    .at_mid_o (at_mid),
    .at_end_o (at_end)
  );

  assign start   = !in_burst && chip_en_i && tx_en_i;
  assign sym_end = in_burst && chip_en_i && at_end;

  pn_sym_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start),
    .inc_i      (sym_end && in_data),
    .in_data_i  (in_data),
    .burst_len_i(burst_len_i),
    .cnt_o      (sym_cnt),
    .last_o     (last_sym)
  );

  assign req = in_burst && tx_en_i && !last_sym && (at_end || (!bpsk_i && at_mid));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      sym_i_q <= 1'b0;
      sym_q_q <= 1'b0;
      nxt_i_q <= 1'b0;
    end else if (chip_en_i) begin
      // capture requested bits; they apply from the next symbol
      if (req) begin
        if (bpsk_i) begin
          sym_i_q <= data_i;
          sym_q_q <= data_i;
        end else if (at_end) begin
          sym_i_q <= nxt_i_q;
          sym_q_q <= data_i;
        end else begin
          nxt_i_q <= data_i;
        end
      end
      unique case (st_q)
        ST_IDLE: if (tx_en_i) begin
          st_q    <= ST_PRE;
          idx_q   <= pre_len_i;
          sym_i_q <= 1'b0;
          sym_q_q <= 1'b0;
        end
        ST_PRE: begin
          if (!at_end)      idx_q <= idx_q - 1'b1;
          else if (tx_en_i) begin
            st_q  <= ST_DATA;
            idx_q <= dat_len_i;
          end else          st_q  <= ST_IDLE;
        end
        ST_DATA: begin
          if (!at_end)                    idx_q <= idx_q - 1'b1;
          else if (last_sym || !tx_en_i)  st_q  <= ST_IDLE;
          else                            idx_q <= dat_len_i;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = req;
  assign active_o   = in_burst;
  assign preamble_o = in_pre;
  assign chip_i_o   = in_burst && (sym_i_q ^ invert_i ^ code_bit);
  assign chip_q_o   = in_burst && (sym_q_q ^ invert_i ^ code_bit);
endmodule

// File: rtl/pn_burst_spreader_chk.sv
module pn_burst_spreader_chk
  import pn_spread_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             chip_en_i,
  input logic             tx_en_i,
  input logic             bpsk_i,
  input logic             req_o,
  input logic             chip_i_o,
  input logic             chip_q_o,
  input logic             active_o,
  input logic [CNT_W-1:0] burst_len_i,
  input tx_st_e           st_q,
  input logic [LEN_W-1:0] idx_q,
  input logic [CNT_W-1:0] sym_cnt
);
  assert_pre_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PRE && chip_en_i && idx_q == '0 && tx_en_i) |=> (st_q == ST_DATA));

  assert_idx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chip_en_i && st_q != ST_IDLE && idx_q != '0) |=> (idx_q == LEN_W'($past(idx_q) - 1'b1)));

  assert_bpsk_q_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && bpsk_i) |-> (chip_q_o == chip_i_o));

  assert_req_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && chip_en_i && bpsk_i) |=> !req_o);

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && burst_len_i != '0) |-> (sym_cnt <= burst_len_i));

  assert_stall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chip_en_i |=> ($stable(idx_q) && $stable(st_q)));
endmodule

bind pn_burst_spreader pn_burst_spreader_chk #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .chip_en_i  (chip_en_i),
  .tx_en_i    (tx_en_i),
  .bpsk_i     (bpsk_i),
  .req_o      (req_o),
  .chip_i_o   (chip_i_o),
  .chip_q_o   (chip_q_o),
  .active_o   (active_o),
  .burst_len_i(burst_len_i),
  .st_q       (st_q),
  .idx_q      (idx_q),
  .sym_cnt    (sym_cnt)
);

// File: tb/tb_pn_burst_spreader.sv
module tb_pn_burst_spreader;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        chip_en_i = 1'b0, tx_en_i = 1'b0, bpsk_i = 1'b1, invert_i = 1'b0;
  logic [63:0] pre_code_i = '0, dat_code_i = '0;
  logic [5:0]  pre_len_i = 6'd1, dat_len_i = 6'd1;
  logic [15:0] burst_len_i = '0;
  logic        data_i = 1'b0;
  logic        req_o, chip_i_o, chip_q_o, active_o, preamble_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pn_burst_spreader dut (
    .clk_i, .rst_ni, .chip_en_i, .tx_en_i, .bpsk_i, .invert_i,
    .pre_code_i, .pre_len_i, .dat_code_i, .dat_len_i, .burst_len_i,
    .data_i, .req_o, .chip_i_o, .chip_q_o, .active_o, .preamble_o
  );

  task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b (active,pre,i,q,req)", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {active_o, preamble_o, chip_i_o, chip_q_o, req_o};
  endfunction

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(outs() == 5'b0, "R1 reset state", outs(), 5'b0);
    rst_ni = 1'b1;
    chip_en_i = 1'b1;
    tx_en_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check(outs() == 5'b0, "R2 no start while tx_en low", outs(), 5'b0);
  endtask

  // One full burst; expected stream derived from requirements.
  task automatic run_burst(input bit bp, input bit inv, input bit cont, input bit gap,
                           input logic [5:0] pl, input logic [5:0] dl, input int nsym,
                           input logic [63:0] pc, input logic [63:0] dc,
                           input logic [127:0] bits, input string tag);
    int ptr = 0;
    @(negedge clk_i);
    bpsk_i = bp; invert_i = inv; pre_len_i = pl; dat_len_i = dl;
    pre_code_i = pc; dat_code_i = dc;
    burst_len_i = cont ? 16'd0 : 16'(nsym - 1);
    chip_en_i = 1'b1; tx_en_i = 1'b1; data_i = 1'b0;
    for (int s = -1; s < nsym; s++) begin
      int  len = (s < 0) ? int'(pl) : int'(dl);
      int  mid = len + 1 - (len + 1) / 2;
      bit  last = (s == nsym - 1);
      logic bi = 1'b0, bq = 1'b0;
      if (s >= 0) begin
        bi = bp ? bits[s] : bits[2*s];
        bq = bp ? bits[s] : bits[2*s+1];
      end
      for (int k = len; k >= 0; k--) begin
        logic cb, er;
        logic [4:0] e, a;
        @(negedge clk_i);
        if (cont && last && k == len) tx_en_i = 1'b0;
        cb = (s < 0) ? pc[k] : dc[k];
        er = !last && (k == 0 || (!bp && k == mid));
        e  = {1'b1, s < 0, bi ^ inv ^ cb, bq ^ inv ^ cb, er};
        a  = outs();
        check(a == e, tag, a, e);
        data_i = er ? bits[ptr] : ~bits[ptr];
        if (er) ptr++;
        if (gap) begin
          chip_en_i = 1'b0;
          @(negedge clk_i);
          check(outs() == e, "R11 hold while strobe low", outs(), e);
          chip_en_i = 1'b1;
        end
      end
    end
    @(negedge clk_i);
    check(active_o == 1'b0, cont ? "R9 idle after tx_en drop" : "R8 idle after last symbol",
          outs(), 5'b0);
    tx_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(outs() == 5'b0, "R2 stays idle", outs(), 5'b0);
  endtask

  task automatic t_bpsk_counted();
    run_burst(1, 0, 0, 0, 6'd6, 6'd4, 3, 64'h0000_0000_0000_0059, 64'h0000_0000_0000_0016,
              128'b101, "R2 R3 R4 R5 R7 R8 bpsk counted");
  endtask

  task automatic t_qpsk_gap();
    run_burst(0, 0, 0, 1, 6'd7, 6'd5, 2, 64'h0000_0000_0000_00B3, 64'h0000_0000_0000_002D,
              128'b0110, "R3 R6 R11 qpsk stalled strobe");
  endtask

  task automatic t_bpsk_cont_inv();
    run_burst(1, 1, 1, 0, 6'd3, 6'd2, 4, 64'h0000_0000_0000_0009, 64'h0000_0000_0000_0005,
              128'b0110, "R9 R10 bpsk continuous inverted");
  endtask

  task automatic t_qpsk_short_code();
    run_burst(0, 0, 0, 0, 6'd63, 6'd1, 3, 64'hF0E1_D2C3_B4A5_9687, 64'h0000_0000_0000_0002,
              128'b10_01_11, "R6 R7 qpsk two-chip data code");
  endtask

  task automatic t_qpsk_cont_inv();
    run_burst(0, 1, 1, 0, 6'd2, 6'd3, 3, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_000C,
              128'b01_10_11, "R6 R9 R10 qpsk continuous inverted");
  endtask

  initial begin
    t_reset();
    t_bpsk_counted();
    t_qpsk_gap();
    t_bpsk_cont_inv();
    t_qpsk_short_code();
    t_qpsk_cont_inv();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule